// File: doc/BRIEF.md
# Interrupt Acceptance and Response-Mode Controller

This block sits beside an 8-bit processor's instruction decoder. It owns the maskable-interrupt enable pair, the response-mode register and the vector-page register. At every instruction boundary the sequencer raises a strobe, and the block decides whether a soft reset, a non-maskable interrupt or a maskable interrupt takes over the next cycle. It then reports the response the sequencer must carry out: a fixed restart address, a request to run the byte that the interrupting device placed on the data bus, or an indirect-call table address built from the vector-page register and that byte.

Between boundaries the decoder sends it single-cycle commands. These disable or enable interrupts, return from a non-maskable handler (which restores the saved enable), select the response mode from a 3-bit opcode field, or load the vector page. The enable used by the parity/overflow flag when the I or R register is read is available at all times. Pushing the return address and executing the supplied opcode are left to the sequencer.

Top module: `irq_ack_ctrl`

## Requirements
- R1: When `boundary` is high, a request for a soft reset (`rst_req`) wins over a pending non-maskable interrupt, and that interrupt wins over `int_req`. When `boundary` is low, no event is accepted. Event codes on `evt_code`: 0 none, 1 reset, 2 non-maskable, 3 execute bus byte, 4 fixed restart, 5 table call.
- R2: `int_req` is accepted only while `iff1` is 1. A request refused because `iff1` is 0 is not remembered: it is re-examined only as the level present at a later boundary.
- R3: On an accepted non-maskable interrupt, `iff2` takes the old value of `iff1`, `iff1` becomes 0, and `tgt_addr` is 0x0066.
- R4: An accepted maskable interrupt clears `iff1` and `iff2`. In mode 0 the code is 3 and `tgt_addr` is {0x00, `ack_data`}. In mode 1 the code is 4 and `tgt_addr` is 0x0038. In mode 2 the code is 5 and `tgt_addr` is {vector page, `ack_data`}.
- R5: Command DI (`cmd_op`=1) clears both enables. Command EI (`cmd_op`=2) sets both.
- R6: Command RETN (`cmd_op`=3) copies `iff2` into `iff1` and leaves `iff2` unchanged.
- R7: Command SETIM (`cmd_op`=4) takes the mode from `cmd_arg[2:0]`. Values 2 and 6 give mode 1, values 3 and 7 give mode 2, and values 0, 1, 4 and 5 give mode 0.
- R8: Command LDI (`cmd_op`=5) loads the vector page from `cmd_arg`.
- R9: An accepted reset clears both enables and the vector page, sets mode 0, reports `tgt_addr` 0x0000, and discards a pending non-maskable interrupt.
- R10: `nmi_req` is latched on its rising edge. One edge produces exactly one acceptance, however long the level is held.
- R11: `evt_code`, `tgt_addr` and a one-cycle `halt_clr` pulse appear in the cycle after the accepting boundary. `halt_clr` is high for every accepted event and low otherwise.
- R12: `pv_flag` always equals `iff2`.
- R13: A command that arrives in the same cycle as an accepted event is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary | input | 1 | Instruction-boundary strobe |
| rst_req | input | 1 | Soft reset request, level |
| nmi_req | input | 1 | Non-maskable request, rising-edge sensitive |
| int_req | input | 1 | Maskable request, level |
| ack_data | input | 8 | Byte read in the acknowledge cycle |
| cmd_valid | input | 1 | Decoder command strobe |
| cmd_op | input | 3 | Command: 1 DI, 2 EI, 3 RETN, 4 SETIM, 5 LDI |
| cmd_arg | input | 8 | Mode field (bits 2:0) or vector page |
| evt_code | output | 3 | Accepted event code |
| tgt_addr | output | 16 | Restart, opcode or table address |
| halt_clr | output | 1 | Halt-release pulse |
| iff1 | output | 1 | Live maskable enable |
| iff2 | output | 1 | Saved enable |
| int_mode | output | 2 | Response mode |
| pv_flag | output | 1 | Enable copy for the I/R-read flag |

## Verification
Simultaneous request mixes (reset+NMI+INT, NMI+INT, INT alone) separate the priority order from the masking rule. Maskable requests offered in each mode, with distinct bus bytes and vector pages, show that the response depends on the mode and that the page comes from the register, including after a reset has cleared it. The sequences NMI-then-RETN, taken from both enabled and disabled states, show that the saved enable is restored rather than forced. Every alias of the mode field, a held NMI level, and a command colliding with an event cover the remaining corner rules.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0, CMD_DI = 3'd1, CMD_EI = 3'd2,
    CMD_RETN = 3'd3, CMD_SETIM = 3'd4, CMD_LDI = 3'd5
  } cmd_e;

  typedef enum logic [2:0] {
    EV_NONE = 3'd0, EV_RESET = 3'd1, EV_NMI = 3'd2,
    EV_EXEC = 3'd3, EV_FIXED = 3'd4, EV_TABLE = 3'd5
  } evt_e;

  typedef enum logic [1:0] {K_NONE, K_RESET, K_NMI, K_INT} kind_e;

  // mode field aliasing: low two bits 2 -> mode 1, 3 -> mode 2, else mode 0
  function automatic logic [1:0] mode_of_field(input logic [2:0] f);
    unique case (f[1:0])
      2'd2:    mode_of_field = 2'd1;
      2'd3:    mode_of_field = 2'd2;
      default: mode_of_field = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic  boundary,
  input  logic  rst_req,
  input  logic  nmi_pend,
  input  logic  int_req,
  input  logic  iff1,
  output kind_e kind
);
  always_comb begin
    kind = K_NONE;
    if (boundary) begin
      if (rst_req)               kind = K_RESET;
      else if (nmi_pend)         kind = K_NMI;
      else if (int_req && iff1)  kind = K_INT;
    end
  end
endmodule

// File: rtl/irq_resp.sv
module irq_resp
  import irq_pkg::*;
#(
  parameter int DW        = 8,
  parameter int AW        = 16,
  parameter logic [AW-1:0] NMI_ADDR  = 16'h0066,
  parameter logic [AW-1:0] FIXED_ADDR = 16'h0038
) (
  input  kind_e         kind,
  input  logic [1:0]    mode,
  input  logic [DW-1:0] bus_byte,
  input  logic [DW-1:0] page,
  output evt_e          code,
  output logic [AW-1:0] addr
);
  localparam int PW = AW - DW;

  always_comb begin
    code = EV_NONE;
    addr = '0;
    unique case (kind)
      K_RESET: code = EV_RESET;
      K_NMI: begin
        code = EV_NMI;
        addr = NMI_ADDR;
      end
      K_INT: begin
        unique case (mode)
          2'd1: begin
            code = EV_FIXED;
            addr = FIXED_ADDR;
          end
          2'd2: begin
            code = EV_TABLE;
            addr = {{(PW-DW){1'b0}}, page, bus_byte};
          end
          default: begin
            code = EV_EXEC;
            addr = {{PW{1'b0}}, bus_byte};
          end
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_state.sv
module irq_state
  import irq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  kind_e         kind,
  input  logic          cmd_valid,
  input  cmd_e          cmd_op,
  input  logic [DW-1:0] cmd_arg,
  output logic          iff1_q,
  output logic          iff2_q,
  output logic [1:0]    mode_q,
  output logic [DW-1:0] page_q
);
  logic          iff1_d, iff2_d;
  logic [1:0]    mode_d;
  logic [DW-1:0] page_d;

  always_comb begin
    iff1_d = iff1_q;
    iff2_d = iff2_q;
    mode_d = mode_q;
    page_d = page_q;
    unique case (kind)
      K_RESET: begin
        iff1_d = 1'b0;
        iff2_d = 1'b0;
        mode_d = 2'd0;
        page_d = '0;
      end
      K_NMI: begin
        iff2_d = iff1_q;
        iff1_d = 1'b0;
      end
      K_INT: begin
        iff1_d = 1'b0;
        iff2_d = 1'b0;
      end
      default: begin
        if (cmd_valid) begin
          unique case (cmd_op)
            CMD_DI: begin
              iff1_d = 1'b0;
              iff2_d = 1'b0;
            end
            CMD_EI: begin
              iff1_d = 1'b1;
              iff2_d = 1'b1;
            end
            CMD_RETN:  iff1_d = iff2_q;
            CMD_SETIM: mode_d = mode_of_field(cmd_arg[2:0]);
            CMD_LDI:   page_d = cmd_arg;
            default: ;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iff1_q <= 1'b0;
      iff2_q <= 1'b0;
      mode_q <= 2'd0;
      page_q <= '0;
    end else begin
      iff1_q <= iff1_d;
      iff2_q <= iff2_d;
      mode_q <= mode_d;
      page_q <= page_d;
    end
  end
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary,
  input  logic              rst_req,
  input  logic              nmi_req,
  input  logic              int_req,
  input  logic [DW-1:0]     ack_data,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [DW-1:0]     cmd_arg,
  output logic [2:0]        evt_code,
  output logic [2*DW-1:0]   tgt_addr,
  output logic              halt_clr,
  output logic              iff1,
  output logic              iff2,
  output logic [1:0]        int_mode,
  output logic              pv_flag
);
  localparam int AW = 2 * DW;

  kind_e         kind;
  evt_e          code_d;
  logic [AW-1:0] addr_d;
  logic [DW-1:0] page_q;
  logic          nmi_prev_q, nmi_pend_q, nmi_pend_d;
  evt_e          evt_q;
  logic [AW-1:0] tgt_q;
  logic          halt_q;
  logic          tgt_en;

  irq_arbiter u_arb (
    .boundary (boundary),
    .rst_req  (rst_req),
    .nmi_pend (nmi_pend_q),
    .int_req  (int_req),
    .iff1     (iff1),
    .kind     (kind)
  );

  irq_resp #(.DW(DW), .AW(AW)) u_resp (
    .kind     (kind),
    .mode     (int_mode),
    .bus_byte (ack_data),
    .page     (page_q),
    .code     (code_d),
    .addr     (addr_d)
  );

  irq_state #(.DW(DW)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .kind      (kind),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_e'(cmd_op)),
    .cmd_arg   (cmd_arg),
    .iff1_q    (iff1),
    .iff2_q    (iff2),
    .mode_q    (int_mode),
    .page_q    (page_q)
  );

  // rising edge of the NMI line arms the pending latch; acceptance or reset disarms it
  always_comb begin
    nmi_pend_d = nmi_pend_q;
    if (kind == K_NMI || kind == K_RESET) nmi_pend_d = 1'b0;
    if (nmi_req && !nmi_prev_q)           nmi_pend_d = 1'b1;
  end

  assign tgt_en = (kind != K_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_prev_q <= 1'b0;
      nmi_pend_q <= 1'b0;
      evt_q      <= EV_NONE;
      halt_q     <= 1'b0;
      tgt_q      <= '0;
    end else begin
      nmi_prev_q <= nmi_req;
      nmi_pend_q <= nmi_pend_d;
      evt_q      <= code_d;
      halt_q     <= tgt_en;
      if (tgt_en) tgt_q <= addr_d;
    end
  end

  assign evt_code = evt_q;
  assign tgt_addr = tgt_q;
  assign halt_clr = halt_q;
  assign pv_flag  = iff2;
endmodule

// File: rtl/irq_ack_ctrl_chk.sv
module irq_ack_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        boundary,
  input logic        rst_req,
  input logic        cmd_valid,
  input logic [2:0]  cmd_op,
  input logic [2:0]  evt_code,
  input logic [15:0] tgt_addr,
  input logic        halt_clr,
  input logic        iff1,
  input logic        iff2,
  input logic [7:0]  page_q
);
  logic is_int;
  assign is_int = (evt_code == 3'd3) || (evt_code == 3'd4) || (evt_code == 3'd5);

  a_r1_needs_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_code != 3'd0) |-> $past(boundary));

  a_r1_reset_first: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_code == 3'd2 || is_int) |-> !$past(rst_req));

  a_r2_int_masked: assert property (@(posedge clk) disable iff (!rst_n)
    is_int |-> $past(iff1));

  a_r3_nmi_save: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_code == 3'd2) |-> (!iff1 && iff2 == $past(iff1) && tgt_addr == 16'h0066));

  a_r4_int_clear: assert property (@(posedge clk) disable iff (!rst_n)
    is_int |-> (!iff1 && !iff2));

  a_r4_table_page: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_code == 3'd5) |-> (tgt_addr[15:8] == $past(page_q)));

  a_r6_retn: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_valid && cmd_op == 3'd3) && evt_code == 3'd0) |-> (iff1 == $past(iff2)));

  a_r11_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_clr && $past(!boundary)) |-> 1'b0);

  a_r9_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_code == 3'd1) |-> (!iff1 && !iff2 && page_q == 8'h00));
endmodule

bind irq_ack_ctrl irq_ack_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .boundary  (boundary),
  .rst_req   (rst_req),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .evt_code  (evt_code),
  .tgt_addr  (tgt_addr),
  .halt_clr  (halt_clr),
  .iff1      (iff1),
  .iff2      (iff2),
  .page_q    (page_q)
);

// File: tb/sim_irq_ack_ctrl.sv
`timescale 1ns/1ps
module sim_irq_ack_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boundary = 1'b0, rst_req = 1'b0, nmi_req = 1'b0, int_req = 1'b0;
  logic [7:0]  ack_data = 8'h00;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [7:0]  cmd_arg = 8'h00;
  logic [2:0]  evt_code;
  logic [15:0] tgt_addr;
  logic        halt_clr, iff1, iff2, pv_flag;
  logic [1:0]  int_mode;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_ack_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .rst_req(rst_req),
    .nmi_req(nmi_req), .int_req(int_req), .ack_data(ack_data),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .evt_code(evt_code), .tgt_addr(tgt_addr), .halt_clr(halt_clr),
    .iff1(iff1), .iff2(iff2), .int_mode(int_mode), .pv_flag(pv_flag)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [7:0]  arg;
    logic        nmi;
    logic        intr;
    logic        rst;
    logic [7:0]  data;
    logic [2:0]  code;
    logic [15:0] tgt;
    logic        f1;
    logic        f2;
    logic [1:0]  im;
  } vec_t;

  localparam int NV = 24;
  // op: 1 DI, 2 EI, 3 RETN, 4 SETIM, 5 LDI; code: 0 none 1 reset 2 nmi 3 exec 4 fixed 5 table
  localparam vec_t VEC [NV] = '{
    '{3'd0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 3'd0, 16'h0000, 1'b0, 1'b0, 2'd0}, // R2 masked
    '{3'd2, 8'h00, 1'b0, 1'b1, 1'b0, 8'hC7, 3'd3, 16'h00C7, 1'b0, 1'b0, 2'd0}, // R4 mode 0
    '{3'd2, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 16'h0000, 1'b1, 1'b1, 2'd0}, // R5 EI
    '{3'd4, 8'h06, 1'b0, 1'b1, 1'b0, 8'hAA, 3'd4, 16'h0038, 1'b0, 1'b0, 2'd1}, // R4 mode 1
    '{3'd2, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 3'd2, 16'h0066, 1'b0, 1'b1, 2'd1}, // R3
    '{3'd3, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 16'h0000, 1'b1, 1'b1, 2'd1}, // R6
    '{3'd4, 8'h07, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 16'h0000, 1'b1, 1'b1, 2'd2}, // R7
    '{3'd5, 8'h12, 1'b0, 1'b1, 1'b0, 8'h34, 3'd5, 16'h1234, 1'b0, 1'b0, 2'd2}, // R8 R4 mode 2
    '{3'd2, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 3'd2, 16'h0066, 1'b0, 1'b1, 2'd2}, // R1 nmi over int
    '{3'd0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 3'd0, 16'h0000, 1'b0, 1'b1, 2'd2}, // R2
    '{3'd3, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 16'h0000, 1'b1, 1'b1, 2'd2}, // R6 restore
    '{3'd1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 16'h0000, 1'b0, 1'b0, 2'd2}, // R5 DI, R2 not latched
    '{3'd2, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00, 3'd1, 16'h0000, 1'b0, 1'b0, 2'd0}, // R1 R9 reset wins
    '{3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 16'h0000, 1'b0, 1'b0, 2'd0}, // R9 nmi discarded
    '{3'd4, 8'h02, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 16'h0000, 1'b0, 1'b0, 2'd1}, // R7
    '{3'd4, 8'h05, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 16'h0000, 1'b0, 1'b0, 2'd0}, // R7
    '{3'd4, 8'h03, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 16'h0000, 1'b0, 1'b0, 2'd2}, // R7
    '{3'd4, 8'h01, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 16'h0000, 1'b0, 1'b0, 2'd0}, // R7
    '{3'd2, 8'h00, 1'b0, 1'b1, 1'b0, 8'h56, 3'd3, 16'h0056, 1'b0, 1'b0, 2'd0}, // R4
    '{3'd0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 3'd2, 16'h0066, 1'b0, 1'b0, 2'd0}, // R3 from disabled
    '{3'd3, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 16'h0000, 1'b0, 1'b0, 2'd0}, // R6
    '{3'd4, 8'h03, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 16'h0000, 1'b0, 1'b0, 2'd2}, // R7
    '{3'd2, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 16'h0000, 1'b1, 1'b1, 2'd2}, // R5
    '{3'd0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h9A, 3'd5, 16'h009A, 1'b0, 1'b0, 2'd2}  // R9 page cleared
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [7:0] arg);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0; cmd_arg = 8'h00;
  endtask

  task automatic nmi_pulse();
    @(negedge clk); nmi_req = 1'b1;
    @(negedge clk); nmi_req = 1'b0;
  endtask

  task automatic at_boundary(input logic r, input logic i, input logic [7:0] d);
    @(negedge clk);
    boundary = 1'b1; rst_req = r; int_req = i; ack_data = d;
    @(negedge clk);
    boundary = 1'b0; rst_req = 1'b0; int_req = 1'b0; ack_data = 8'h00;
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(evt_code == 3'd0, "R9", "reset code", evt_code, 0);
    chk(!iff1 && !iff2, "R9", "reset enables", {iff1, iff2}, 0);
    chk(int_mode == 2'd0, "R9", "reset mode", int_mode, 0);
    chk(!halt_clr, "R11", "reset halt_clr", halt_clr, 0);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k].op != 3'd0) do_cmd(VEC[k].op, VEC[k].arg);
      if (VEC[k].nmi) nmi_pulse();
      at_boundary(VEC[k].rst, VEC[k].intr, VEC[k].data);
      chk(evt_code == VEC[k].code, "R1", $sformatf("vec %0d code", k), evt_code, VEC[k].code);
      if (VEC[k].code != 3'd0)
        chk(tgt_addr == VEC[k].tgt, "R4", $sformatf("vec %0d target", k), tgt_addr, VEC[k].tgt);
      chk(iff1 == VEC[k].f1, "R5", $sformatf("vec %0d iff1", k), iff1, VEC[k].f1);
      chk(iff2 == VEC[k].f2, "R6", $sformatf("vec %0d iff2", k), iff2, VEC[k].f2);
      chk(int_mode == VEC[k].im, "R7", $sformatf("vec %0d mode", k), int_mode, VEC[k].im);
      chk(halt_clr == (VEC[k].code != 3'd0), "R11", $sformatf("vec %0d halt_clr", k),
          halt_clr, VEC[k].code != 3'd0);
      chk(pv_flag == VEC[k].f2, "R12", $sformatf("vec %0d pv_flag", k), pv_flag, VEC[k].f2);
    end

    // R11: the pulse lasts one cycle
    at_boundary(1'b0, 1'b0, 8'h00);
    do_cmd(3'd2, 8'h00);
    nmi_pulse();
    at_boundary(1'b0, 1'b0, 8'h00);
    chk(halt_clr, "R11", "pulse high", halt_clr, 1);
    @(negedge clk);
    chk(!halt_clr && evt_code == 3'd0, "R11", "pulse gone", {halt_clr, evt_code}, 0);

    // R13: EI together with an accepted NMI is dropped (state was 0/1 after NMI)
    do_cmd(3'd1, 8'h00);
    nmi_pulse();
    @(negedge clk);
    boundary = 1'b1; cmd_valid = 1'b1; cmd_op = 3'd2;
    @(negedge clk);
    boundary = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0;
    chk(evt_code == 3'd2, "R13", "nmi taken", evt_code, 2);
    chk(!iff1 && !iff2, "R13", "EI dropped", {iff1, iff2}, 0);

    // R10: held level yields one acceptance
    @(negedge clk); nmi_req = 1'b1;
    at_boundary(1'b0, 1'b0, 8'h00);
    chk(evt_code == 3'd2, "R10", "first accept", evt_code, 2);
    at_boundary(1'b0, 1'b0, 8'h00);
    chk(evt_code == 3'd0, "R10", "held level ignored", evt_code, 0);
    nmi_req = 1'b0;

    // R1: no boundary, no event, even with requests present
    do_cmd(3'd2, 8'h00);
    @(negedge clk); int_req = 1'b1; rst_req = 1'b1;
    @(negedge clk);
    chk(evt_code == 3'd0 && iff1, "R1", "no boundary", {evt_code, iff1}, 1);
    int_req = 1'b0; rst_req = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule